// File: doc/BRIEF.md
# Isochronous Cycle Timing Event Monitor

This block sits beside an isochronous cycle timer and the link's arbitration logic. It turns timer field movement and link strobes into single-clock event pulses. A new-cycle pulse marks every toggle of the cycle count's least significant bit. A separate pulse marks each change of bit 6 of the seconds field, which happens every 64 seconds. The block also compares the seconds and count fields of every received cycle-start header against the local timer and pulses when they disagree.

Two supervisory functions follow the cycle period. The lost-cycle monitor watches cycle-start strobes (sent or received) and the gap strobes between new-cycle events. It reports a missing cycle start either at the next new-cycle event or early, from the order in which the gaps arrive, and it never reports more than once per period. While the node acts as cycle master, the over-long monitor counts microsecond ticks from each transmitted cycle start to the end of the next subaction gap. Past the limit, it pulses an event together with a request to clear the master enable.

Every strobe input is a synchronous one-cycle pulse. Every output is registered and rises on the clock edge that samples its cause. The external reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `cyc_evt_mon`

## Requirements
- R1: `synch_o` pulses for one clock after every clock edge at which bit 0 of `tmr_cnt_i` differs from its value at the previous edge. Changes in the other bits of `tmr_cnt_i` produce no pulse.
- R2: `sec64_o` pulses for one clock after every edge at which bit 6 of `tmr_sec_i` has changed. Changes confined to bits 5:0 produce no pulse.
- R3: `incons_o` pulses one clock after an edge with `rx_start_i` high when `rx_sec_i` differs from `tmr_sec_i` or `rx_cnt_i` differs from `tmr_cnt_i`, in any bit. It stays low when both fields match or when `rx_start_i` is low.
- R4: When a new-cycle event ends a period in which neither `tx_start_i` nor `rx_start_i` was seen, and no loss was reported, `lost_o` pulses with the same latency as `synch_o`. The first new-cycle event after reset never reports a loss.
- R5: Within a period with no cycle start yet, a second subaction gap or an arbitration reset gap following the first subaction gap makes `lost_o` pulse one clock later. If a cycle start comes first, there is no pulse.
- R6: An arbitration reset gap arriving in a period before any cycle start makes `lost_o` pulse one clock later. If it arrives after the cycle start, there is no pulse.
- R7: `lost_o` pulses at most once per period. After an early report, further gaps and the closing new-cycle event produce no pulse.
- R8: With `master_en_i` high, `too_long_o` pulses one clock after a `sub_gap_i` strobe when more than LIMIT (125) `us_tick_i` strobes were counted since the last `tx_start_i`. It stays low for exactly LIMIT ticks or fewer. Only the first subaction gap after a cycle start is judged.
- R9: `master_clr_o` pulses in exactly the same clocks as `too_long_o`.
- R10: With `master_en_i` low, `too_long_o` and `master_clr_o` stay low regardless of ticks and gaps.
- R11: During reset and after its release, all outputs are low. The first sample taken after reset never produces a `synch_o` or `sec64_o` pulse, whatever the timer inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_sec_i | input | 7 | Timer seconds field |
| tmr_cnt_i | input | 13 | Timer cycle count field |
| rx_start_i | input | 1 | Received cycle-start header strobe |
| rx_sec_i | input | 7 | Seconds field of received cycle start |
| rx_cnt_i | input | 13 | Count field of received cycle start |
| tx_start_i | input | 1 | Cycle-start transmission begins |
| sub_gap_i | input | 1 | End of subaction gap strobe |
| arb_gap_i | input | 1 | Arbitration reset gap strobe |
| us_tick_i | input | 1 | Microsecond tick |
| master_en_i | input | 1 | Cycle master enable |
| synch_o | output | 1 | New isochronous cycle pulse |
| sec64_o | output | 1 | 64-second boundary pulse |
| lost_o | output | 1 | Lost cycle pulse |
| incons_o | output | 1 | Inconsistent cycle start pulse |
| too_long_o | output | 1 | Over-long cycle pulse |
| master_clr_o | output | 1 | Request to clear cycle master enable |

## Verification
The count input is driven with a sequence of 64 arithmetic values. Some steps keep bit 0 and change the higher bits, so they separate a true toggle detector from a general change detector. The seconds field is swept through two full wraps, which shows that only bit 6 transitions count.

The cycle-start comparison is tried against each of the 20 single-bit mismatches and against an exact match, which locates any missing field bit. Lost-cycle scenarios cover a start followed by a gap, a gap followed by a start, two gaps in a row, an arbitration gap alone, and a period ended without a start. Together they separate the early prediction from the late report and show the once-per-period limit.

The over-long check counts from 123 to 128 ticks, bracketing the limit, and repeats 130 ticks with the master enable low.

// File: rtl/cyc_evt_pkg.sv
`timescale 1ns/1ps
package cyc_evt_pkg;
  // Phase of the lost-cycle supervisor within one cycle period
  typedef enum logic [2:0] {
    PH_IDLE,      // no new-cycle event since reset
    PH_WAIT_GAP,  // period open, nothing seen yet
    PH_GAP_SEEN,  // first subaction gap seen, start must come next
    PH_GOT_START, // cycle start seen this period
    PH_FLAGGED    // loss already reported this period
  } lost_phase_e;
endpackage

// File: rtl/cyc_bit_watch.sv
`timescale 1ns/1ps
module cyc_bit_watch #(
  parameter int W   = 13,
  parameter int BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] val_i,
  output logic         chg_o,
  output logic         pulse_o
);
  logic prev_q, primed_q, pulse_q;
  logic prev_d, primed_d, pulse_d;

  always_comb begin
    chg_o    = primed_q && (val_i[BIT] != prev_q);
    prev_d   = val_i[BIT];
    primed_d = 1'b1;
    pulse_d  = chg_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
      pulse_q  <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R1 R2
  property edge_seen_p;
    @(posedge clk) disable iff (!rst_n)
      (primed_q && (val_i[BIT] != prev_q)) |=> pulse_o;
  endproperty
  edge_seen_chk: assert property (edge_seen_p);

  // R1 R2
  property bit_steady_p;
    @(posedge clk) disable iff (!rst_n)
      (val_i[BIT] == prev_q) |=> !pulse_o;
  endproperty
  bit_steady_chk: assert property (bit_steady_p);
endmodule

// File: rtl/cyc_mismatch_chk.sv
`timescale 1ns/1ps
module cyc_mismatch_chk #(
  parameter int SEC_W = 7,
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start_i,
  input  logic [SEC_W-1:0] rx_sec_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [SEC_W-1:0] tmr_sec_i,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  output logic             incons_o
);
  localparam int TOT_W = SEC_W + CNT_W;

  logic [TOT_W-1:0] diff;
  logic             incons_d, incons_q;

  always_comb begin
    diff     = {rx_sec_i, rx_cnt_i} ^ {tmr_sec_i, tmr_cnt_i};
    incons_d = rx_start_i && (|diff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) incons_q <= 1'b0;
    else        incons_q <= incons_d;
  end

  assign incons_o = incons_q;

  // R3
  property no_rx_quiet_p;
    @(posedge clk) disable iff (!rst_n) !rx_start_i |=> !incons_o;
  endproperty
  no_rx_quiet_chk: assert property (no_rx_quiet_p);

  // R3
  property match_quiet_p;
    @(posedge clk) disable iff (!rst_n)
      (rx_sec_i == tmr_sec_i && rx_cnt_i == tmr_cnt_i) |=> !incons_o;
  endproperty
  match_quiet_chk: assert property (match_quiet_p);
endmodule

// File: rtl/cyc_lost_mon.sv
`timescale 1ns/1ps
module cyc_lost_mon
  import cyc_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic synch_i,
  input  logic start_i,
  input  logic sub_gap_i,
  input  logic arb_gap_i,
  output logic lost_o
);
  lost_phase_e phase_q, phase_d, ph_cur;
  logic        lost_q, lost_d, late_loss, early_loss;

  always_comb begin
    // closing the old period
    late_loss = synch_i && (phase_q == PH_WAIT_GAP || phase_q == PH_GAP_SEEN);
    ph_cur    = synch_i ? PH_WAIT_GAP : phase_q;
    phase_d   = ph_cur;
    early_loss = 1'b0;
    case (ph_cur)
      PH_WAIT_GAP: begin
        if (start_i)        phase_d = PH_GOT_START;
        else if (arb_gap_i) begin early_loss = 1'b1; phase_d = PH_FLAGGED; end
        else if (sub_gap_i) phase_d = PH_GAP_SEEN;
      end
      PH_GAP_SEEN: begin
        if (start_i) phase_d = PH_GOT_START;
        else if (sub_gap_i || arb_gap_i) begin
          early_loss = 1'b1;
          phase_d    = PH_FLAGGED;
        end
      end
      default: phase_d = ph_cur;
    endcase
    lost_d = late_loss || early_loss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      lost_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      lost_q  <= lost_d;
    end
  end

  assign lost_o = lost_q;

  // R7
  property once_per_period_p;
    @(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FLAGGED && !synch_i) |=> !lost_o;
  endproperty
  once_per_period_chk: assert property (once_per_period_p);

  // R4
  property missing_start_p;
    @(posedge clk) disable iff (!rst_n)
      (synch_i && (phase_q == PH_WAIT_GAP || phase_q == PH_GAP_SEEN)) |=> lost_o;
  endproperty
  missing_start_chk: assert property (missing_start_p);

  // R4
  property first_period_p;
    @(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && !synch_i) |=> !lost_o;
  endproperty
  first_period_chk: assert property (first_period_p);
endmodule

// File: rtl/cyc_long_mon.sv
`timescale 1ns/1ps
module cyc_long_mon #(
  parameter int LIMIT = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en_i,
  input  logic tx_start_i,
  input  logic sub_gap_i,
  input  logic tick_i,
  output logic too_long_o,
  output logic master_clr_o
);
  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);
  localparam logic [CW-1:0] SAT_C = CW'(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          hit_q, hit_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    hit_d = 1'b0;
    if (!master_en_i) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (tx_start_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (tick_i && cnt_q < SAT_C) cnt_d = cnt_q + 1'b1;
      if (sub_gap_i) begin
        act_d = 1'b0;
        hit_d = (cnt_q > LIM_C);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      hit_q <= hit_d;
    end
  end

  assign too_long_o   = hit_q;
  assign master_clr_o = hit_q;

  // R10
  property master_only_p;
    @(posedge clk) disable iff (!rst_n) !master_en_i |=> !too_long_o;
  endproperty
  master_only_chk: assert property (master_only_p);

  // R8
  property cnt_bound_p;
    @(posedge clk) disable iff (!rst_n) cnt_q <= SAT_C;
  endproperty
  cnt_bound_chk: assert property (cnt_bound_p);

  // R8
  property gap_needed_p;
    @(posedge clk) disable iff (!rst_n) !sub_gap_i |=> !too_long_o;
  endproperty
  gap_needed_chk: assert property (gap_needed_p);
endmodule

// File: rtl/cyc_evt_mon.sv
`timescale 1ns/1ps
module cyc_evt_mon #(
  parameter int SEC_W   = 7,
  parameter int CNT_W   = 13,
  parameter int SEC_BIT = 6,
  parameter int LIMIT   = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] tmr_sec_i,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  input  logic             rx_start_i,
  input  logic [SEC_W-1:0] rx_sec_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             tx_start_i,
  input  logic             sub_gap_i,
  input  logic             arb_gap_i,
  input  logic             us_tick_i,
  input  logic             master_en_i,
  output logic             synch_o,
  output logic             sec64_o,
  output logic             lost_o,
  output logic             incons_o,
  output logic             too_long_o,
  output logic             master_clr_o
);
  logic rst_meta_q, rst_sync_q;
  logic synch_now, sec_now_unused, any_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign any_start = tx_start_i | rx_start_i;

  cyc_bit_watch #(.W(CNT_W), .BIT(0)) u_cnt_watch (
    .clk(clk), .rst_n(rst_sync_q), .val_i(tmr_cnt_i),
    .chg_o(synch_now), .pulse_o(synch_o)
  );

  cyc_bit_watch #(.W(SEC_W), .BIT(SEC_BIT)) u_sec_watch (
    .clk(clk), .rst_n(rst_sync_q), .val_i(tmr_sec_i),
    .chg_o(sec_now_unused), .pulse_o(sec64_o)
  );

  cyc_mismatch_chk #(.SEC_W(SEC_W), .CNT_W(CNT_W)) u_mismatch (
    .clk(clk), .rst_n(rst_sync_q), .rx_start_i(rx_start_i),
    .rx_sec_i(rx_sec_i), .rx_cnt_i(rx_cnt_i),
    .tmr_sec_i(tmr_sec_i), .tmr_cnt_i(tmr_cnt_i), .incons_o(incons_o)
  );

  cyc_lost_mon u_lost (
    .clk(clk), .rst_n(rst_sync_q), .synch_i(synch_now), .start_i(any_start),
    .sub_gap_i(sub_gap_i), .arb_gap_i(arb_gap_i), .lost_o(lost_o)
  );

  cyc_long_mon #(.LIMIT(LIMIT)) u_long (
    .clk(clk), .rst_n(rst_sync_q), .master_en_i(master_en_i),
    .tx_start_i(tx_start_i), .sub_gap_i(sub_gap_i), .tick_i(us_tick_i),
    .too_long_o(too_long_o), .master_clr_o(master_clr_o)
  );

  // R9
  property clr_with_event_p;
    @(posedge clk) disable iff (!rst_sync_q) too_long_o |-> master_clr_o;
  endproperty
  clr_with_event_chk: assert property (clr_with_event_p);

  // R11
  property reset_quiet_p;
    @(posedge clk) !rst_sync_q |-> !(synch_o || sec64_o || lost_o || incons_o || too_long_o);
  endproperty
  reset_quiet_chk: assert property (reset_quiet_p);
endmodule

// File: tb/cyc_evt_mon_tb.sv
`timescale 1ns/1ps
module cyc_evt_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  tmr_sec_i, rx_sec_i;
  logic [12:0] tmr_cnt_i, rx_cnt_i;
  logic        rx_start_i, tx_start_i, sub_gap_i, arb_gap_i, us_tick_i, master_en_i;
  logic        synch_o, sec64_o, lost_o, incons_o, too_long_o, master_clr_o;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cyc_evt_mon dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_sec_i(tmr_sec_i), .tmr_cnt_i(tmr_cnt_i),
    .rx_start_i(rx_start_i), .rx_sec_i(rx_sec_i), .rx_cnt_i(rx_cnt_i),
    .tx_start_i(tx_start_i), .sub_gap_i(sub_gap_i), .arb_gap_i(arb_gap_i),
    .us_tick_i(us_tick_i), .master_en_i(master_en_i),
    .synch_o(synch_o), .sec64_o(sec64_o), .lost_o(lost_o), .incons_o(incons_o),
    .too_long_o(too_long_o), .master_clr_o(master_clr_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one-cycle strobe event, then outputs are sampled by the caller
  task automatic evt(input logic tx, input logic sg, input logic ag);
    tx_start_i = tx; sub_gap_i = sg; arb_gap_i = ag;
    step();
    tx_start_i = 1'b0; sub_gap_i = 1'b0; arb_gap_i = 1'b0;
  endtask

  task automatic new_cycle();
    tmr_cnt_i = tmr_cnt_i + 13'd1;
    step();
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [12:0] nv;
    logic [6:0]  sv;
    logic [19:0] m;
    rst_n = 1'b0;
    tmr_sec_i = 7'h40; tmr_cnt_i = 13'd5;
    rx_sec_i = '0; rx_cnt_i = '0;
    rx_start_i = 0; tx_start_i = 0; sub_gap_i = 0; arb_gap_i = 0;
    us_tick_i = 0; master_en_i = 0;
    repeat (4) @(negedge clk);
    // R11: outputs quiet under reset
    chk("R11 synch in reset", synch_o, 1'b0);
    chk("R11 lost in reset", lost_o, 1'b0);
    rst_n = 1'b1;
    repeat (5) step();
    // R11: first samples after reset produce no pulse
    chk("R11 synch", synch_o, 1'b0);
    chk("R11 sec64", sec64_o, 1'b0);
    chk("R11 lost", lost_o, 1'b0);
    chk("R11 incons", incons_o, 1'b0);
    chk("R11 too_long", too_long_o, 1'b0);
    chk("R11 master_clr", master_clr_o, 1'b0);

    // R1 sweep: arithmetic values, some keep bit 0
    for (int i = 1; i <= 64; i++) begin
      nv = 13'(i * i * 7 + i * 2);
      sv = 7'(0);
      begin
        logic exp1;
        exp1 = (nv[0] != tmr_cnt_i[0]);
        tmr_cnt_i = nv;
        step();
        chk("R1 synch sweep", synch_o, exp1);
      end
    end

    // R2 sweep: seconds field over two wraps
    for (int i = 1; i <= 256; i++) begin
      logic exp2;
      sv = 7'(i + 64);
      exp2 = (sv[6] != tmr_sec_i[6]);
      tmr_sec_i = sv;
      step();
      chk("R2 sec64 sweep", sec64_o, exp2);
      if (i % 16 == 0) chk("R1 synch steady", synch_o, 1'b0);
    end

    // R3 comparison
    tmr_sec_i = 7'h35; tmr_cnt_i = 13'h0A5C;
    step();
    rx_sec_i = tmr_sec_i; rx_cnt_i = tmr_cnt_i; rx_start_i = 1'b1;
    step(); rx_start_i = 1'b0;
    chk("R3 match", incons_o, 1'b0);
    for (int b = 0; b < 20; b++) begin
      m = 20'd1 << b;
      {rx_sec_i, rx_cnt_i} = {tmr_sec_i, tmr_cnt_i} ^ m;
      rx_start_i = 1'b1;
      step(); rx_start_i = 1'b0;
      chk("R3 mismatch bit", incons_o, 1'b1);
    end
    step();
    chk("R3 no strobe", incons_o, 1'b0);

    // Lost-cycle scenarios (tx_start used as the cycle start)
    new_cycle();
    evt(1, 0, 0);
    new_cycle();
    chk("R4 start seen", lost_o, 1'b0);
    new_cycle();
    chk("R4 no start", lost_o, 1'b1);
    evt(0, 1, 0);  chk("R5 first gap", lost_o, 1'b0);
    evt(1, 0, 0);  chk("R5 start after gap", lost_o, 1'b0);
    new_cycle();   chk("R5 period ok", lost_o, 1'b0);
    evt(0, 1, 0);  chk("R5 gap one", lost_o, 1'b0);
    evt(0, 1, 0);  chk("R5 gap two", lost_o, 1'b1);
    evt(0, 0, 1);  chk("R7 arb after report", lost_o, 1'b0);
    evt(0, 1, 0);  chk("R7 gap after report", lost_o, 1'b0);
    new_cycle();   chk("R7 close after report", lost_o, 1'b0);
    evt(0, 0, 1);  chk("R6 arb before start", lost_o, 1'b1);
    new_cycle();   chk("R7 close after arb", lost_o, 1'b0);
    evt(1, 0, 0);
    evt(0, 0, 1);  chk("R6 arb after start", lost_o, 1'b0);
    new_cycle();   chk("R6 period ok", lost_o, 1'b0);
    evt(0, 1, 0);
    evt(0, 0, 1);  chk("R5 arb after gap", lost_o, 1'b1);
    new_cycle();   chk("R7 single report", lost_o, 1'b0);

    // R8/R9: bracket the limit
    master_en_i = 1'b1;
    for (int n = 123; n <= 128; n++) begin
      evt(1, 0, 0);
      for (int k = 0; k < n; k++) begin
        us_tick_i = 1'b1; step(); us_tick_i = 1'b0;
      end
      evt(0, 1, 0);
      chk("R8 too_long", too_long_o, n > 125);
      chk("R9 master_clr", master_clr_o, n > 125);
      step();
      chk("R8 single clock", too_long_o, 1'b0);
    end
    // R8: only first gap after a start counts
    evt(1, 0, 0);
    for (int k = 0; k < 130; k++) begin
      us_tick_i = 1'b1; step(); us_tick_i = 1'b0;
    end
    evt(0, 1, 0);
    chk("R8 over limit", too_long_o, 1'b1);
    evt(0, 1, 0);
    chk("R8 second gap", too_long_o, 1'b0);

    // R10: master disabled
    master_en_i = 1'b0;
    evt(1, 0, 0);
    for (int k = 0; k < 130; k++) begin
      us_tick_i = 1'b1; step(); us_tick_i = 1'b0;
    end
    evt(0, 1, 0);
    chk("R10 too_long off", too_long_o, 1'b0);
    chk("R10 master_clr off", master_clr_o, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule